// File: doc/BRIEF.md
# Partitioned SIMD Integer Lane ALU

This block is a packed integer datapath for a 128-bit vector unit. Each accepted operation takes two 128-bit operands plus a third 128-bit operand that serves as an accumulator or a lane mask. It applies one function to every lane at the same time. The lane width is picked per operation: sixteen 8-bit lanes, eight 16-bit lanes, four 32-bit lanes or two 64-bit lanes. Lanes never interact. Carries and products stop at the boundary of the chosen lane.

Besides lane arithmetic and predicated selection, the block performs three data-movement operations on 64-bit halves. The first copies the low 64 bits of A into both halves of the result. The other two merge A's low 64 bits into only the upper or only the lower half of B and leave B's other half as it was.

Operations enter on a valid/ready port. When `in_valid` and `in_ready` are both high at a rising clock edge, the operation is accepted. Its result appears on `out_data`, with `out_valid` high, after that same edge. A result stays on the port, unchanged, until a rising edge where `out_ready` is high. `in_ready` is high while the output holds no result or while the output is being drained in the same cycle. A producer may therefore issue one operation per cycle when the consumer never stalls.

Top module: `simd_lane_alu`

## Requirements
- R1: While `rst_n` is low and at the first edge after it rises, `out_valid` is 0.
- R2: `in_ready` equals `!out_valid || out_ready`. An operation accepted at an edge gives `out_valid`=1 with its result after that edge. While `out_valid`=1 and `out_ready`=0, `out_data` and `out_valid` hold.
- R3: The lane-size code `in_size` selects the lane width: 00 = 8 bits, 01 = 16 bits, 10 = 32 bits, 11 = 64 bits. Lane i occupies bits [i*W +: W].
- R4: Opcode 000 (add): each lane is (a + b) mod 2^W, and no carry crosses a lane boundary.
- R5: Opcode 001 (multiply): each lane is the low W bits of a × b.
- R6: Opcode 010 (multiply-add): each lane is (c + a × b) mod 2^W.
- R7: Opcode 011 (select): each lane is taken from A when the most significant bit of the same lane of C is 1, and from B otherwise.
- R8: Opcode 100 (broadcast): both 64-bit halves of the result equal a[63:0], whatever the lane size.
- R9: Opcode 101 (move high): the result is {a[63:0], b[63:0]}, whatever the lane size.
- R10: Opcode 110 (move low): the result is {b[127:64], a[63:0]}, whatever the lane size.
- R11: Opcode 111 is reserved and gives an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| in_op | input | 3 | Opcode |
| in_size | input | 2 | Lane-size code |
| in_a | input | 128 | Operand A |
| in_b | input | 128 | Operand B, and the destination for the half moves |
| in_c | input | 128 | Accumulator for multiply-add, mask for select |
| out_valid | output | 1 | Result held on `out_data` |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Registered result |

## Verification
A lane boundary placed at the wrong size, or a carry chain left uncut, shows up in the first result after the faulty operation. It corrupts only the lane just above the boundary. All-ones plus one and sign-boundary operands make this visible in a single lane. A wrong select bit or a swapped half in the moves shows up as whole lanes or halves taken from the wrong operand, on the very next valid result. A fault in the output holding register appears as a result that changes or vanishes during a stall. It also appears as a `in_ready` that is high while a stalled result is still waiting.

// File: rtl/simd_lane_pkg.sv
package simd_lane_pkg;
  localparam int VEC_W     = 128;
  localparam int HALF_W    = VEC_W / 2;
  localparam int NUM_SIZES = 4;
  localparam int MIN_LANE  = 8;

  typedef enum logic [2:0] {
    OP_ADD   = 3'b000,
    OP_MUL   = 3'b001,
    OP_MADD  = 3'b010,
    OP_SEL   = 3'b011,
    OP_BCAST = 3'b100,
    OP_MOVH  = 3'b101,
    OP_MOVL  = 3'b110,
    OP_RSVD  = 3'b111
  } lane_op_e;

  typedef struct packed {
    logic [VEC_W-1:0] add;
    logic [VEC_W-1:0] mul;
    logic [VEC_W-1:0] madd;
    logic [VEC_W-1:0] sel;
  } slice_res_t;
endpackage

// File: rtl/simd_lane_slice.sv
module simd_lane_slice #(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 8
) (
  input  logic [VEC_W-1:0] op_a,
  input  logic [VEC_W-1:0] op_b,
  input  logic [VEC_W-1:0] op_c,
  output logic [VEC_W-1:0] add_o,
  output logic [VEC_W-1:0] mul_o,
  output logic [VEC_W-1:0] madd_o,
  output logic [VEC_W-1:0] sel_o
);
  localparam int LANES = VEC_W / LANE_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] la, lb, lc, prod;
    assign la   = op_a[i*LANE_W +: LANE_W];
    assign lb   = op_b[i*LANE_W +: LANE_W];
    assign lc   = op_c[i*LANE_W +: LANE_W];
    assign prod = la * lb;
    assign add_o[i*LANE_W +: LANE_W]  = la + lb;
    assign mul_o[i*LANE_W +: LANE_W]  = prod;
    assign madd_o[i*LANE_W +: LANE_W] = lc + prod;
    assign sel_o[i*LANE_W +: LANE_W]  = lc[LANE_W-1] ? la : lb;
  end
endmodule

// File: rtl/simd_half_mover.sv
module simd_half_mover #(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0] op_a,
  input  logic [VEC_W-1:0] op_b,
  output logic [VEC_W-1:0] bcast_o,
  output logic [VEC_W-1:0] movh_o,
  output logic [VEC_W-1:0] movl_o
);
  localparam int HW = VEC_W / 2;

  assign bcast_o = {op_a[HW-1:0], op_a[HW-1:0]};
  assign movh_o  = {op_a[HW-1:0], op_b[HW-1:0]};
  assign movl_o  = {op_b[VEC_W-1:HW], op_a[HW-1:0]};
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_lane_pkg::*;
#(
  parameter int DATA_W = VEC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic [1:0]        in_size,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [DATA_W-1:0] in_c,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic [NUM_SIZES-1:0][DATA_W-1:0] add_v, mul_v, madd_v, sel_v;
  logic [DATA_W-1:0] bcast_v, movh_v, movl_v;
  logic [DATA_W-1:0] res_d;
  logic              accept;
  lane_op_e          op;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    simd_lane_slice #(.VEC_W(DATA_W), .LANE_W(MIN_LANE << s)) u_slice (
      .op_a  (in_a),
      .op_b  (in_b),
      .op_c  (in_c),
      .add_o (add_v[s]),
      .mul_o (mul_v[s]),
      .madd_o(madd_v[s]),
      .sel_o (sel_v[s])
    );
  end

  simd_half_mover #(.VEC_W(DATA_W)) u_mover (
    .op_a   (in_a),
    .op_b   (in_b),
    .bcast_o(bcast_v),
    .movh_o (movh_v),
    .movl_o (movl_v)
  );

  assign op = lane_op_e'(in_op);

  always_comb begin
    case (op)
      OP_ADD:   res_d = add_v[in_size];
      OP_MUL:   res_d = mul_v[in_size];
      OP_MADD:  res_d = madd_v[in_size];
      OP_SEL:   res_d = sel_v[in_size];
      OP_BCAST: res_d = bcast_v;
      OP_MOVH:  res_d = movh_v;
      OP_MOVL:  res_d = movl_v;
      default:  res_d = '0;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_data  <= res_d;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk #(
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [2:0]        in_op,
  input logic [DATA_W-1:0] in_a,
  input logic [DATA_W-1:0] in_b,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data
);
  localparam int HW = DATA_W / 2;
  logic fire;
  assign fire = in_valid && in_ready;

  assert_accept_gives_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  assert_stall_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_no_accept_on_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_bcast_halves_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op == 3'b100) |=> (out_data[DATA_W-1:HW] == out_data[HW-1:0]));

  assert_movh_merge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op == 3'b101) |=>
      (out_data == {$past(in_a[HW-1:0]), $past(in_b[HW-1:0])}));

  assert_movl_merge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op == 3'b110) |=>
      (out_data == {$past(in_b[DATA_W-1:HW]), $past(in_a[HW-1:0])}));

  assert_rsvd_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op == 3'b111) |=> (out_data == '0));
endmodule

bind simd_lane_alu simd_lane_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_op    (in_op),
  .in_a     (in_a),
  .in_b     (in_b),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data)
);

// File: tb/simd_lane_alu_tb.sv
module simd_lane_alu_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [2:0]   in_op = '0;
  logic [1:0]   in_size = '0;
  logic [127:0] in_a = '0, in_b = '0, in_c = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  simd_lane_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_size(in_size), .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  typedef struct packed {
    logic [2:0]   op;
    logic [1:0]   size;
    logic [127:0] a;
    logic [127:0] b;
    logic [127:0] c;
    logic [127:0] exp;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    // R4: all-ones plus one in 8-bit lanes, no carry out of any byte
    '{3'd0, 2'd0, {128{1'b1}}, {16{8'h01}}, 128'h0, 128'h0},
    // R4: 64-bit lanes, low lane wraps, high lane untouched
    '{3'd0, 2'd3, {128{1'b1}}, 128'h1, 128'h0, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0}},
    // R4: 16-bit sign boundary
    '{3'd0, 2'd1, {8{16'h7FFF}}, {8{16'h0001}}, 128'h0, {8{16'h8000}}},
    // R5: 8-bit product overflows to zero
    '{3'd1, 2'd0, {16{8'h10}}, {16{8'h10}}, 128'h0, 128'h0},
    // R5: 32-bit lanes
    '{3'd1, 2'd2, {4{32'h0001_0001}}, {4{32'h0000_0003}}, 128'h0, {4{32'h0003_0003}}},
    // R6: accumulator wraps after add
    '{3'd2, 2'd1, {8{16'h0002}}, {8{16'h0003}}, {8{16'hFFFF}}, {8{16'h0005}}},
    // R7: mask msb alternates per byte
    '{3'd3, 2'd0, {16{8'hAA}}, {16{8'h55}}, {8{16'h807F}}, {8{16'hAA55}}},
    // R8
    '{3'd4, 2'd0, {64'h1111_2222_3333_4444, 64'h0123_4567_89AB_CDEF}, 128'h0, 128'h0,
      {2{64'h0123_4567_89AB_CDEF}}},
    // R9
    '{3'd5, 2'd2, {64'hAAAA_AAAA_AAAA_AAAA, 64'h0123_4567_89AB_CDEF},
      {64'hBBBB_BBBB_BBBB_BBBB, 64'hCCCC_CCCC_CCCC_CCCC}, 128'h0,
      {64'h0123_4567_89AB_CDEF, 64'hCCCC_CCCC_CCCC_CCCC}},
    // R10
    '{3'd6, 2'd1, {64'hAAAA_AAAA_AAAA_AAAA, 64'h0123_4567_89AB_CDEF},
      {64'hBBBB_BBBB_BBBB_BBBB, 64'hCCCC_CCCC_CCCC_CCCC}, 128'h0,
      {64'hBBBB_BBBB_BBBB_BBBB, 64'h0123_4567_89AB_CDEF}},
    // R11
    '{3'd7, 2'd0, {128{1'b1}}, {128{1'b1}}, {128{1'b1}}, 128'h0}
  };

  function automatic logic [127:0] ref_model(input logic [2:0] op, input logic [1:0] sz,
      input logic [127:0] a, input logic [127:0] b, input logic [127:0] c);
    logic [127:0] r, m, x, y, z, v;
    int lw;
    lw = 8 << sz;
    m = ({128{1'b1}} >> (128 - lw));
    r = '0;
    case (op)
      3'd4: r = {a[63:0], a[63:0]};
      3'd5: r = {a[63:0], b[63:0]};
      3'd6: r = {b[127:64], a[63:0]};
      3'd7: r = '0;
      default: begin
        for (int i = 0; i < 128 / lw; i++) begin
          x = (a >> (i * lw)) & m;
          y = (b >> (i * lw)) & m;
          z = (c >> (i * lw)) & m;
          case (op)
            3'd0: v = x + y;
            3'd1: v = x * y;
            3'd2: v = z + x * y;
            default: v = z[lw-1] ? x : y;
          endcase
          r = r | ((v & m) << (i * lw));
        end
      end
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [1:0] sz, input logic [127:0] a,
      input logic [127:0] b, input logic [127:0] c, input logic [127:0] exp, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_size = sz; in_a = a; in_b = b; in_c = c;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {127'h0, out_valid}, 128'h1);
    check(req, out_data, exp);
  endtask

  initial begin
    #1;
    check("R1 reset valid", {127'h0, out_valid}, 128'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {127'h0, out_valid}, 128'h0);
    check("R2 ready idle", {127'h0, in_ready}, 128'h1);

    for (int k = 0; k < NVEC; k++)
      run_op(VECS[k].op, VECS[k].size, VECS[k].a, VECS[k].b, VECS[k].c, VECS[k].exp,
             "R3 table vector");

    for (int op = 0; op < 8; op++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int p = 0; p < 6; p++) begin
          logic [127:0] a, b, c;
          a = {$urandom, $urandom, $urandom, $urandom};
          b = {$urandom, $urandom, $urandom, $urandom};
          c = {$urandom, $urandom, $urandom, $urandom};
          if (p == 0) begin a = {128{1'b1}}; b = {128{1'b1}}; end
          if (p == 1) begin a = {16{8'h80}}; b = {16{8'h80}}; c = {16{8'h7F}}; end
          if (p == 2) begin a = {2{64'h7FFF_FFFF_FFFF_FFFF}}; b = {2{64'h8000_0000_0000_0001}}; end
          run_op(3'(op), 2'(sz), a, b, c, ref_model(3'(op), 2'(sz), a, b, c),
                 "R4 R5 R6 R7 R8 R9 R10 R11 sweep");
        end
      end
    end

    // R7: 64-bit lanes, mask msb set only in upper lane
    run_op(3'd3, 2'd3, {128{1'b1}}, 128'h0, {64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF},
           {64'hFFFF_FFFF_FFFF_FFFF, 64'h0}, "R7 wide mask");

    // R2: stall holds result and blocks input
    run_op(3'd0, 2'd0, {16{8'h01}}, {16{8'h02}}, 128'h0, {16{8'h03}}, "R2 pre-stall");
    @(negedge clk);
    in_valid = 1'b1; in_op = 3'd0; in_size = 2'd0; in_a = {16{8'h10}}; in_b = {16{8'h01}};
    out_ready = 1'b0;
    // previous result already drained, so this one is accepted at the next edge
    @(negedge clk);
    check("R2 accepted", out_data, {16{8'h11}});
    in_a = {16{8'h20}};
    check("R2 ready low in stall", {127'h0, in_ready}, 128'h0);
    @(negedge clk);
    check("R2 hold data", out_data, {16{8'h11}});
    check("R2 hold valid", {127'h0, out_valid}, 128'h1);
    out_ready = 1'b1;
    #1;
    check("R2 ready on drain", {127'h0, in_ready}, 128'h1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 after drain", out_data, {16{8'h21}});
    @(negedge clk);
    check("R2 empty", {127'h0, out_valid}, 128'h0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule